// File: doc/BRIEF.md
# Memory Protection Fault Status Recorder

This block sits beside a memory-protection region checker and keeps a record of why and where protection faults happened. The checker reports violations as single-cycle pulses of four kinds: an instruction-fetch violation, a data read or write violation, a violation while pushing an exception frame onto the stack, and a violation while popping one. The recorder folds each pulse into a sticky status byte. For data-side violations it also captures the faulting address and raises an address-valid flag.

Software reads the status byte and the captured address. It clears status bits by writing ones to them through a small clear port. On every cycle that carries a violation, the block issues a one-cycle request on the following cycle. That request goes either to the memory-management exception or, when that exception is disabled, to the hard-fault path.

Top module: `mem_fault_recorder`

## Requirements
- R1: After synchronous reset the status byte is 0x00, the captured address is 0, and neither exception request is asserted.
- R2: An instruction-fetch violation sets status bit 0 on the next cycle. It leaves the address-valid bit (bit 7) clear and does not change the captured address.
- R3: A data violation sets status bit 1 and bit 7 together, so a clean start gives status 0x82. It also captures the data address presented in that same cycle.
- R4: A stacking violation sets status bit 4 and an unstacking violation sets bit 3. Neither sets bit 7 on its own. A stacking violation that comes with a data violation gives status 0x92 with the address captured.
- R5: Status bits are sticky. A clear write with a 1 in a bit position clears that bit, and a 0 leaves it unchanged. When a violation sets a bit in the same cycle as a write clears it, the set wins.
- R6: While bit 7 is set and is not being cleared, a further data violation does not overwrite the captured address. Once bit 7 is cleared, the next data violation captures again.
- R7: Status bits 2, 5 and 6 always read as zero. Clear writes to them have no visible effect.
- R8: In the cycle after any violation, exactly one request pulses for one cycle. It is the memory-management request if the fault enable was high in the violation cycle, and the hard-fault request otherwise.
- R9: When several violation pulses arrive in one cycle, every one of them is recorded, and the address comes from the data-side pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ifetch_viol_i | input | 1 | Instruction-fetch violation pulse |
| data_viol_i | input | 1 | Data read/write violation pulse |
| stack_viol_i | input | 1 | Exception-stacking violation pulse |
| unstack_viol_i | input | 1 | Exception-unstacking violation pulse |
| data_addr_i | input | ADDR_W | Address of the current data access |
| mm_fault_en_i | input | 1 | Memory-management exception enable |
| clr_we_i | input | 1 | Clear-write strobe |
| clr_data_i | input | 8 | Write-one-to-clear mask for the status byte |
| status_o | output | 8 | Sticky fault status byte |
| fault_addr_o | output | ADDR_W | Captured fault address |
| mm_exc_req_o | output | 1 | Memory-management exception request pulse |
| hard_fault_req_o | output | 1 | Escalated hard-fault request pulse |

## Verification
The assertions assume that each violation input is a clean synchronous level, sampled once per clock. They also assume that the data address is steady in any cycle where the data violation is high. The bench drives all inputs on the falling edge and holds each violation for exactly one cycle, with the address already in place. It makes every clear write on a falling edge, either on its own or alongside a pulse in the one set-versus-clear test, so that every sampled value is unambiguous.

// File: rtl/mfsr_pkg.sv
package mfsr_pkg;

    localparam int STAT_W     = 8;
    localparam int B_IFETCH   = 0;
    localparam int B_DATA     = 1;
    localparam int B_UNSTACK  = 3;
    localparam int B_STACK    = 4;
    localparam int B_AVALID   = 7;

    localparam logic [STAT_W-1:0] IMPL_MASK = 8'h9B;

    typedef struct packed {
        logic ifetch;
        logic data;
        logic stack;
        logic unstack;
    } viol_t;

    function automatic logic [STAT_W-1:0] viol_to_set(input viol_t v);
        logic [STAT_W-1:0] s;
        s = '0;
        s[B_IFETCH]  = v.ifetch;
        s[B_DATA]    = v.data;
        s[B_UNSTACK] = v.unstack;
        s[B_STACK]   = v.stack;
        s[B_AVALID]  = v.data;
        return s;
    endfunction

    function automatic logic any_viol(input viol_t v);
        return v.ifetch | v.data | v.stack | v.unstack;
    endfunction

endpackage

// File: rtl/mfsr_status_bits.sv
module mfsr_status_bits
    import mfsr_pkg::*;
#(
    parameter int W = STAT_W,
    parameter logic [W-1:0] MASK = IMPL_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);

    logic [W-1:0] q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (MASK[b]) begin : g_impl
            always_ff @(posedge clk) begin
                if (rst)           q[b] <= 1'b0;
                else if (set_i[b]) q[b] <= 1'b1;
                else if (clr_i[b]) q[b] <= 1'b0;
            end

            a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
                (q[b] && !clr_i[b]) |=> q[b]);
            a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
                set_i[b] |=> q[b]);
        end else begin : g_rsvd
            always_comb q[b] = 1'b0;
        end
    end

    assign status_o = q;

endmodule

// File: rtl/mfsr_addr_capture.sv
module mfsr_addr_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_viol_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              valid_q_i,
    input  logic              valid_clr_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_q;
    logic              take;

    always_comb take = data_viol_i && (!valid_q_i || valid_clr_i);

    always_ff @(posedge clk) begin
        if (rst)       addr_q <= '0;
        else if (take) addr_q <= addr_i;
    end

    assign addr_o = addr_q;

    a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (valid_q_i && !valid_clr_i) |=> $stable(addr_o));
    a_r3_addr_capture: assert property (@(posedge clk) disable iff (rst)
        (data_viol_i && !valid_q_i) |=> (addr_o == $past(addr_i)));

endmodule

// File: rtl/mfsr_escalate.sv
module mfsr_escalate (
    input  logic clk,
    input  logic rst,
    input  logic any_viol_i,
    input  logic en_i,
    output logic mm_req_o,
    output logic hf_req_o
);

    logic mm_q, hf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mm_q <= 1'b0;
            hf_q <= 1'b0;
        end else begin
            mm_q <= any_viol_i &&  en_i;
            hf_q <= any_viol_i && !en_i;
        end
    end

    assign mm_req_o = mm_q;
    assign hf_req_o = hf_q;

    a_r8_one_req: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mm_req_o, hf_req_o}));
    a_r8_escalate: assert property (@(posedge clk) disable iff (rst)
        (any_viol_i && !en_i) |=> (hf_req_o && !mm_req_o));
    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        !any_viol_i |=> !(mm_req_o || hf_req_o));

endmodule

// File: rtl/mem_fault_recorder.sv
module mem_fault_recorder
    import mfsr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ifetch_viol_i,
    input  logic              data_viol_i,
    input  logic              stack_viol_i,
    input  logic              unstack_viol_i,
    input  logic [ADDR_W-1:0] data_addr_i,
    input  logic              mm_fault_en_i,
    input  logic              clr_we_i,
    input  logic [7:0]        clr_data_i,
    output logic [7:0]        status_o,
    output logic [ADDR_W-1:0] fault_addr_o,
    output logic              mm_exc_req_o,
    output logic              hard_fault_req_o
);

    viol_t             viol;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] stat;

    always_comb begin
        viol.ifetch  = ifetch_viol_i;
        viol.data    = data_viol_i;
        viol.stack   = stack_viol_i;
        viol.unstack = unstack_viol_i;
        set_vec      = viol_to_set(viol);
        clr_vec      = clr_we_i ? clr_data_i : '0;
    end

    mfsr_status_bits #(.W(STAT_W), .MASK(IMPL_MASK)) u_status (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .status_o (stat)
    );

    mfsr_addr_capture #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .data_viol_i (data_viol_i),
        .addr_i      (data_addr_i),
        .valid_q_i   (stat[B_AVALID]),
        .valid_clr_i (clr_vec[B_AVALID]),
        .addr_o      (fault_addr_o)
    );

    mfsr_escalate u_esc (
        .clk        (clk),
        .rst        (rst),
        .any_viol_i (any_viol(viol)),
        .en_i       (mm_fault_en_i),
        .mm_req_o   (mm_exc_req_o),
        .hf_req_o   (hard_fault_req_o)
    );

    assign status_o = stat;

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (status_o & 8'h64) == 8'h00);
    a_r2_ifetch_no_valid: assert property (@(posedge clk) disable iff (rst)
        (ifetch_viol_i && !data_viol_i && !status_o[7]) |=> !status_o[7]);
    a_r3_data_sets: assert property (@(posedge clk) disable iff (rst)
        data_viol_i |=> (status_o[1] && status_o[7]));
    a_r4_stack_sets: assert property (@(posedge clk) disable iff (rst)
        stack_viol_i |=> status_o[4]);
    a_r4_unstack_sets: assert property (@(posedge clk) disable iff (rst)
        unstack_viol_i |=> status_o[3]);

endmodule

// File: tb/tb_mem_fault_recorder.sv
module tb_mem_fault_recorder;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          ifv, dv, sv, uv, en, cwe;
    logic [AW-1:0] addr;
    logic [7:0]    cdata;
    logic [7:0]    status;
    logic [AW-1:0] faddr;
    logic          mmr, hfr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mem_fault_recorder #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst),
        .ifetch_viol_i(ifv), .data_viol_i(dv), .stack_viol_i(sv), .unstack_viol_i(uv),
        .data_addr_i(addr), .mm_fault_en_i(en),
        .clr_we_i(cwe), .clr_data_i(cdata),
        .status_o(status), .fault_addr_o(faddr),
        .mm_exc_req_o(mmr), .hard_fault_req_o(hfr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one-cycle violation pulse with optional clear in the same cycle
    task automatic pulse(input logic i, input logic d, input logic s, input logic u,
                         input logic [AW-1:0] a, input logic e,
                         input logic w, input logic [7:0] c);
        @(negedge clk);
        ifv = i; dv = d; sv = s; uv = u; addr = a; en = e; cwe = w; cdata = c;
        @(negedge clk);
        ifv = 0; dv = 0; sv = 0; uv = 0; cwe = 0; cdata = 0;
    endtask

    task automatic wclr(input logic [7:0] c);
        @(negedge clk);
        cwe = 1; cdata = c;
        @(negedge clk);
        cwe = 0; cdata = 0;
    endtask

    task automatic t_reset;
        chk("R1 status", status, 8'h00);
        chk("R1 addr", faddr, 0);
        chk("R1 reqs", {mmr, hfr}, 2'b00);
    endtask

    task automatic t_ifetch;
        pulse(1, 0, 0, 0, 32'hDEAD_0000, 1, 0, 0);
        chk("R2 status", status, 8'h01);
        chk("R2 addr untouched", faddr, 0);
        chk("R8 mm request", {mmr, hfr}, 2'b10);
        @(negedge clk);
        chk("R8 single pulse", {mmr, hfr}, 2'b00);
        wclr(8'h01);
        chk("R5 clear bit0", status, 8'h00);
    endtask

    task automatic t_data;
        pulse(0, 1, 0, 0, 32'h1000_0040, 0, 0, 0);
        chk("R3 status", status, 8'h82);
        chk("R3 addr", faddr, 32'h1000_0040);
        chk("R8 hard fault", {mmr, hfr}, 2'b01);
        pulse(0, 1, 0, 0, 32'h0000_2222, 1, 0, 0);
        chk("R6 addr held", faddr, 32'h1000_0040);
        chk("R6 status", status, 8'h82);
        wclr(8'h02);
        chk("R5 clear only bit1", status, 8'h80);
        wclr(8'h00);
        chk("R5 zero write no effect", status, 8'h80);
        wclr(8'h80);
        chk("R5 clear valid", status, 8'h00);
        pulse(0, 1, 0, 0, 32'h0000_3333, 1, 0, 0);
        chk("R6 recapture", faddr, 32'h0000_3333);
        wclr(8'hFF);
        chk("R5 clear all", status, 8'h00);
    endtask

    task automatic t_reserved;
        wclr(8'h64);
        chk("R7 reserved zero", status, 8'h00);
        pulse(1, 0, 1, 1, 32'h0, 1, 0, 0);
        chk("R7 reserved after faults", status & 8'h64, 8'h00);
        chk("R4 stack/unstack no valid", status, 8'h19);
        wclr(8'hFF);
    endtask

    task automatic t_stack;
        pulse(0, 1, 1, 0, 32'h2003_E038, 1, 0, 0);
        chk("R4 overflow status", status, 8'h92);
        chk("R4 overflow addr", faddr, 32'h2003_E038);
        wclr(8'hFF);
        pulse(0, 0, 0, 1, 32'h4444_0000, 0, 0, 0);
        chk("R4 unstack status", status, 8'h08);
        chk("R4 unstack addr kept", faddr, 32'h2003_E038);
        chk("R8 unstack hard fault", {mmr, hfr}, 2'b01);
        wclr(8'hFF);
    endtask

    task automatic t_multi;
        pulse(1, 1, 1, 1, 32'h5555_AAA0, 1, 0, 0);
        chk("R9 all recorded", status, 8'h9B);
        chk("R9 addr from data", faddr, 32'h5555_AAA0);
        wclr(8'hFF);
    endtask

    task automatic t_set_wins;
        pulse(1, 0, 0, 0, 32'h0, 1, 1, 8'h01);
        chk("R5 set wins", status, 8'h01);
        pulse(0, 1, 0, 0, 32'h0000_7770, 1, 1, 8'h80);
        chk("R6 capture on clear cycle", faddr, 32'h0000_7770);
        chk("R6 valid set", status, 8'h83);
        wclr(8'hFF);
    endtask

    initial begin
        rst = 1; ifv = 0; dv = 0; sv = 0; uv = 0; en = 0; cwe = 0; cdata = 0; addr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_ifetch();
        t_data();
        t_reserved();
        t_stack();
        t_multi();
        t_set_wins();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule